// File: doc/BRIEF.md
# Multi-exposure HDR pixel merger

The block fuses several co-located pixel samples, one from each of a set of frames shot at different exposure times, into one fixed-point log-radiance value. Each sample is looked up in a camera-response table. The log of its exposure time is then subtracted from the table value, which gives one radiance estimate per exposure. These estimates are averaged with weights shaped like a hat: a sample close to mid-scale counts most, and a sample near black or near saturation counts least. The result is therefore neither a plain mean nor a choice of one exposure.

Samples arrive as one tuple per clock behind a valid/ready handshake, together with start-of-frame and end-of-line markers. The merged stream leaves with the same markers after a fixed pipeline delay. A stalled consumer freezes the whole pipeline. Before streaming starts, software loads the response table and the per-exposure log-exposure constants through a single write port. The response curve is calibrated offline.

Top module: `hdr_merge_top`

## Requirements
- R1: While reset is applied, and in the first cycle after it is released, out_valid is 0 and in_ready is 1.
- R2: Each sample z in 0..1023 gets the weight w(z) = z when z <= 511, and w(z) = 1023 - z otherwise.
- R3: For each exposure p, d_p = g[z_p] - L_p, where g and L are signed Q6.10 (16 bit). The output is (sum of w(z_p)*d_p) / (sum of w(z_p)). The division truncates toward zero, and the result is a 17-bit signed Q6.10 value.
- R4: When every weight is zero (each sample is 0 or 1023), the output is d_m of the middle exposure m = P/2, which is exposure 1 for P = 2 and for P = 3.
- R5: A tuple accepted at a clock edge shows on out_valid 5 edges later. With out_ready held at 1, one tuple is accepted on every clock.
- R6: out_sof and out_eol equal the in_sof and in_eol of the tuple whose result is shown, and they are never 1 while out_valid is 0.
- R7: While out_valid is 1 and out_ready is 0, in_ready is 0, and on the next clock out_valid, out_lograd, out_sof and out_eol are unchanged.
- R8: A clocked write with cfg_we = 1 does one of two things. With cfg_kind = 0 it stores cfg_data in g[cfg_addr]. With cfg_kind = 1 it stores cfg_data in L[cfg_addr], for cfg_addr < P. Tuples accepted later use the new contents.
- R9: Exposure p is carried in in_pix[10p+9 : 10p].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 1 | 0: response table, 1: log-exposure constant |
| cfg_addr | input | 10 | Table index or exposure index |
| cfg_data | input | 16 | Signed Q6.10 value to store |
| in_valid | input | 1 | Input tuple present |
| in_ready | output | 1 | Input tuple accepted this clock |
| in_pix | input | 10*P | P samples, exposure p at bits 10p+9:10p |
| in_sof | input | 1 | Tuple starts a frame |
| in_eol | input | 1 | Tuple ends a line |
| out_valid | output | 1 | Merged value present |
| out_ready | input | 1 | Consumer takes the merged value |
| out_lograd | output | 17 | Signed Q6.10 log radiance |
| out_sof | output | 1 | Start-of-frame of the merged value |
| out_eol | output | 1 | End-of-line of the merged value |

## Verification
A wrong weight, response entry or log-exposure constant shows up as a wrong out_lograd five cycles after the tuple that used it. Sweeping one sample through every code catches an error on either side of the mid-scale knee. A flag shift register that is out of step with the data shows the markers on the wrong output word, and the first line already reveals it. A broken stall shows as a dropped, repeated or changed result on the first cycle in which out_ready is low.

// File: rtl/hdr_merge_pkg.sv
package hdr_merge_pkg;

    typedef struct packed {
        logic valid;
        logic sof;
        logic eol;
    } hdr_tag_t;

    typedef enum logic {
        CFG_RESP  = 1'b0,
        CFG_LNEXP = 1'b1
    } cfg_kind_e;

    // Hat weight with the lower code fixed at zero and the upper at zmax
    function automatic int hat_weight(input int z, input int zmax);
        int mid;
        mid = zmax / 2;
        return (z <= mid) ? z : (zmax - z);
    endfunction

endpackage

// File: rtl/hdr_resp_table.sv
module hdr_resp_table
    import hdr_merge_pkg::*;
#(
    parameter int NEXP  = 3,
    parameter int PIX_W = 10,
    parameter int VAL_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_we,
    input  logic                    cfg_kind,
    input  logic [PIX_W-1:0]        cfg_addr,
    input  logic [VAL_W-1:0]        cfg_data,
    input  logic [NEXP*PIX_W-1:0]   rd_idx,
    output logic [NEXP*VAL_W-1:0]   rd_resp,
    output logic [NEXP*VAL_W-1:0]   ln_out
);
    localparam int DEPTH = 1 << PIX_W;

    logic [VAL_W-1:0] resp_mem [DEPTH];
    logic [VAL_W-1:0] ln_q     [NEXP];

    always_ff @(posedge clk) begin
        if (cfg_we && cfg_kind == CFG_RESP)
            resp_mem[cfg_addr] <= cfg_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NEXP; i++) ln_q[i] <= '0;
        end else if (cfg_we && cfg_kind == CFG_LNEXP) begin
            for (int i = 0; i < NEXP; i++)
                if (cfg_addr == PIX_W'(i)) ln_q[i] <= cfg_data;
        end
    end

    for (genvar i = 0; i < NEXP; i++) begin : g_port
        assign rd_resp[i*VAL_W +: VAL_W] = resp_mem[rd_idx[i*PIX_W +: PIX_W]];
        assign ln_out[i*VAL_W +: VAL_W]  = ln_q[i];
    end

endmodule

// File: rtl/hdr_term_lane.sv
module hdr_term_lane
    import hdr_merge_pkg::*;
#(
    parameter int PIX_W = 10,
    parameter int VAL_W = 16,
    localparam int DIFF_W = VAL_W + 1,
    localparam int PROD_W = DIFF_W + PIX_W + 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic [PIX_W-1:0]         z,
    input  logic signed [VAL_W-1:0]  resp,
    input  logic signed [VAL_W-1:0]  ln_exp,
    output logic signed [PROD_W-1:0] prod_q,
    output logic [PIX_W-1:0]         wgt_q,
    output logic signed [DIFF_W-1:0] diff_q
);
    localparam int ZMAX = (1 << PIX_W) - 1;

    logic [PIX_W-1:0]         w_b;
    logic signed [DIFF_W-1:0] d_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            w_b    <= '0;
            d_b    <= '0;
            prod_q <= '0;
            wgt_q  <= '0;
            diff_q <= '0;
        end else if (en) begin
            w_b    <= PIX_W'(hat_weight(int'(z), ZMAX));
            d_b    <= DIFF_W'(resp) - DIFF_W'(ln_exp);
            prod_q <= PROD_W'($signed({1'b0, w_b})) * PROD_W'(d_b);
            wgt_q  <= w_b;
            diff_q <= d_b;
        end
    end

endmodule

// File: rtl/hdr_merge_div.sv
module hdr_merge_div #(
    parameter int NEXP   = 3,
    parameter int PIX_W  = 10,
    parameter int PROD_W = 28,
    parameter int DIFF_W = 17,
    localparam int SUM_W  = PROD_W + $clog2(NEXP + 1),
    localparam int WSUM_W = PIX_W + $clog2(NEXP + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic [NEXP*PROD_W-1:0]   prod_flat,
    input  logic [NEXP*PIX_W-1:0]    wgt_flat,
    input  logic signed [DIFF_W-1:0] mid_diff,
    output logic signed [DIFF_W-1:0] result_q
);
    logic signed [SUM_W-1:0]  psum_c, psum_q, den, quot;
    logic [WSUM_W-1:0]        wsum_c, wsum_q;
    logic signed [DIFF_W-1:0] mid_q;

    always_comb begin
        psum_c = '0;
        wsum_c = '0;
        for (int i = 0; i < NEXP; i++) begin
            psum_c = psum_c + SUM_W'($signed(prod_flat[i*PROD_W +: PROD_W]));
            wsum_c = wsum_c + WSUM_W'(wgt_flat[i*PIX_W +: PIX_W]);
        end
    end

    always_comb begin
        den  = (wsum_q == '0) ? SUM_W'(1) : {{(SUM_W-WSUM_W){1'b0}}, wsum_q};
        quot = psum_q / den;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            psum_q   <= '0;
            wsum_q   <= '0;
            mid_q    <= '0;
            result_q <= '0;
        end else if (en) begin
            psum_q   <= psum_c;
            wsum_q   <= wsum_c;
            mid_q    <= mid_diff;
            result_q <= (wsum_q == '0) ? mid_q : quot[DIFF_W-1:0];
        end
    end

endmodule

// File: rtl/hdr_merge_top.sv
module hdr_merge_top
    import hdr_merge_pkg::*;
#(
    parameter int NEXP  = 3,
    parameter int PIX_W = 10,
    parameter int VAL_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic                  cfg_kind,
    input  logic [PIX_W-1:0]      cfg_addr,
    input  logic [VAL_W-1:0]      cfg_data,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [NEXP*PIX_W-1:0] in_pix,
    input  logic                  in_sof,
    input  logic                  in_eol,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [VAL_W:0]        out_lograd,
    output logic                  out_sof,
    output logic                  out_eol
);
    localparam int DIFF_W = VAL_W + 1;
    localparam int PROD_W = DIFF_W + PIX_W + 1;
    localparam int MID    = NEXP / 2;
    localparam int LAT    = 5;

    logic                    en;
    hdr_tag_t                tag_q [LAT];
    logic [NEXP*PIX_W-1:0]   z_q;
    logic [NEXP*VAL_W-1:0]   resp_flat, ln_flat;
    logic [NEXP*PROD_W-1:0]  prod_flat;
    logic [NEXP*PIX_W-1:0]   wgt_flat;
    logic [NEXP*DIFF_W-1:0]  diff_flat;
    logic signed [DIFF_W-1:0] result;

    assign en       = !tag_q[LAT-1].valid || out_ready;
    assign in_ready = en;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LAT; i++) tag_q[i] <= '0;
            z_q <= '0;
        end else if (en) begin
            tag_q[0] <= '{valid: in_valid, sof: in_valid & in_sof, eol: in_valid & in_eol};
            for (int i = 1; i < LAT; i++) tag_q[i] <= tag_q[i-1];
            z_q <= in_pix;
        end
    end

    hdr_resp_table #(.NEXP(NEXP), .PIX_W(PIX_W), .VAL_W(VAL_W)) u_table (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data), .rd_idx(z_q),
        .rd_resp(resp_flat), .ln_out(ln_flat)
    );

    for (genvar p = 0; p < NEXP; p++) begin : g_lane
        hdr_term_lane #(.PIX_W(PIX_W), .VAL_W(VAL_W)) u_lane (
            .clk(clk), .rst(rst), .en(en),
            .z(z_q[p*PIX_W +: PIX_W]),
            .resp($signed(resp_flat[p*VAL_W +: VAL_W])),
            .ln_exp($signed(ln_flat[p*VAL_W +: VAL_W])),
            .prod_q(prod_flat[p*PROD_W +: PROD_W]),
            .wgt_q(wgt_flat[p*PIX_W +: PIX_W]),
            .diff_q(diff_flat[p*DIFF_W +: DIFF_W])
        );
    end

    hdr_merge_div #(.NEXP(NEXP), .PIX_W(PIX_W), .PROD_W(PROD_W), .DIFF_W(DIFF_W)) u_div (
        .clk(clk), .rst(rst), .en(en),
        .prod_flat(prod_flat), .wgt_flat(wgt_flat),
        .mid_diff($signed(diff_flat[MID*DIFF_W +: DIFF_W])),
        .result_q(result)
    );

    assign out_valid  = tag_q[LAT-1].valid;
    assign out_sof    = tag_q[LAT-1].sof;
    assign out_eol    = tag_q[LAT-1].eol;
    assign out_lograd = result;

endmodule

// File: rtl/hdr_merge_chk.sv
module hdr_merge_chk #(
    parameter int VAL_W = 16
) (
    input logic           clk,
    input logic           rst,
    input logic           in_ready,
    input logic           out_valid,
    input logic           out_ready,
    input logic [VAL_W:0] out_lograd,
    input logic           out_sof,
    input logic           out_eol
);
    logic rst_q = 1'b0;

    always_ff @(posedge clk) rst_q <= rst;

    always_ff @(posedge clk) begin
        if (rst_q) begin
            // R1
            reset_idle_chk: assert (!out_valid && in_ready);
        end
    end

    // R6
    sof_qualified_chk: assert property (@(posedge clk) disable iff (rst)
        out_sof |-> out_valid);

    // R6
    eol_qualified_chk: assert property (@(posedge clk) disable iff (rst)
        out_eol |-> out_valid);

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_lograd)
                                       && $stable(out_sof) && $stable(out_eol)));

    // R7
    stall_block_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

endmodule

bind hdr_merge_top hdr_merge_chk #(.VAL_W(VAL_W)) u_chk (
    .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_lograd(out_lograd), .out_sof(out_sof),
    .out_eol(out_eol)
);

// File: tb/test_hdr_merge_top.sv
`timescale 1ns/1ps
module test_hdr_merge_top;
    localparam int NEXP = 3;

    typedef struct { int v; bit s; bit e; } exp_t;

    logic        clk = 0, rst = 1;
    logic        cfg_we = 0, cfg_kind = 0;
    logic [9:0]  cfg_addr = '0;
    logic [15:0] cfg_data = '0;
    logic        in_valid = 0, in_sof = 0, in_eol = 0, out_ready = 0;
    logic [29:0] in_pix = '0;
    logic        in_ready, out_valid, out_sof, out_eol;
    logic [16:0] out_lograd;

    hdr_merge_top i_hdr_merge_top (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data), .in_valid(in_valid),
        .in_ready(in_ready), .in_pix(in_pix), .in_sof(in_sof), .in_eol(in_eol),
        .out_valid(out_valid), .out_ready(out_ready), .out_lograd(out_lograd),
        .out_sof(out_sof), .out_eol(out_eol)
    );

    always #10 clk = ~clk;

    int   n_chk = 0, n_bad = 0, cyc = 0;
    int   lnv [NEXP];
    int   zz  [NEXP];
    exp_t q [$];
    int   mode_g = 0, rmode = 0, item_idx = 0, item_cnt = 0;
    int   acc_cyc = 0, pop_cyc = 0;
    bit   held = 0, done = 0;
    logic [16:0] held_v;

    function automatic int gval(int z);
        return z * 45 - 20000;
    endfunction

    function automatic int hatw(int z);
        return (z <= 511) ? z : 1023 - z;
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic drive(int idx);
        for (int p = 0; p < NEXP; p++) begin
            if (mode_g == 1) zz[p] = ((idx >> p) & 1) ? 1023 : 0;
            else if (p == 0) zz[p] = idx % 1024;
            else if (p == 1) zz[p] = (idx * 7 + 300) % 1024;
            else             zz[p] = (idx * 13 + 511) % 1024;
            in_pix[p*10 +: 10] = zz[p][9:0];
        end
        in_sof = (mode_g == 0) && (idx == 0);
        in_eol = (idx % 64) == 63;
    endtask

    function automatic int expect_val();
        int num = 0, den = 0;
        for (int p = 0; p < NEXP; p++) begin
            num += hatw(zz[p]) * (gval(zz[p]) - lnv[p]);
            den += hatw(zz[p]);
        end
        return (den == 0) ? gval(zz[1]) - lnv[1] : num / den;
    endfunction

    task automatic step();
        exp_t e;
        out_ready = (rmode == 0) ? 1'b1 : ((cyc % 3) != 2);
        if (item_idx < item_cnt) begin in_valid = 1; drive(item_idx); end
        else begin in_valid = 0; in_sof = 0; in_eol = 0; end
        #1;
        if (held) begin
            // R7: held result unchanged, input blocked while held
            check(out_valid && out_lograd == held_v, "R7 hold", int'($signed(out_lograd)), int'($signed(held_v)));
        end
        if (out_valid && !out_ready)
            check(!in_ready, "R7 ready", in_ready, 0);
        held   = out_valid && !out_ready;
        held_v = out_lograd;
        if (out_valid && out_ready) begin
            if (q.size() == 0) check(0, "R5 extra output", 1, 0);
            else begin
                e = q.pop_front();
                pop_cyc = cyc;
                // R2 R3 R4 R8 R9: merged value
                check(int'($signed(out_lograd)) == e.v, "R3 value", int'($signed(out_lograd)), e.v);
                // R6: markers follow their pixel
                check(out_sof == e.s && out_eol == e.e, "R6 flags", {out_sof, out_eol}, {e.s, e.e});
            end
        end
        if (in_valid && in_ready) begin
            e.v = expect_val(); e.s = in_sof; e.e = in_eol;
            q.push_back(e);
            acc_cyc = cyc;
            item_idx++;
        end
        cyc++;
        @(negedge clk);
    endtask

    task automatic run(int m, int cnt, int rm);
        mode_g = m; rmode = rm; item_idx = 0; item_cnt = cnt;
        while (item_idx < item_cnt) step();
        while (q.size() != 0 || out_valid) step();
    endtask

    task automatic cfg(bit kind, int addr, int data);
        cfg_we = 1; cfg_kind = kind; cfg_addr = addr[9:0]; cfg_data = data[15:0];
        @(negedge clk);
        cfg_we = 0;
    endtask

    initial begin
        int c0;
        repeat (3) @(negedge clk);
        #1;
        // R1: idle during reset
        check(!out_valid && in_ready, "R1 in reset", {out_valid, in_ready}, 1);
        rst = 0;
        @(negedge clk); #1;
        check(!out_valid && in_ready, "R1 after reset", {out_valid, in_ready}, 1);
        @(negedge clk);
        // R8: load response table and log-exposure constants
        for (int z = 0; z < 1024; z++) cfg(1'b0, z, gval(z));
        lnv[0] = -3000; lnv[1] = 500; lnv[2] = 4000;
        for (int p = 0; p < NEXP; p++) cfg(1'b1, p, lnv[p]);

        // R5: latency of a single tuple
        run(0, 1, 0);
        check(pop_cyc - acc_cyc == 5, "R5 latency", pop_cyc - acc_cyc, 5);

        // R2 R3 R9: full sweep of exposure 0 under backpressure
        run(0, 1024, 1);

        // R4: every weight zero
        run(1, 8, 0);

        // R8: new constants take effect; R5 throughput one per clock
        lnv[0] = 1200; lnv[1] = -2500; lnv[2] = 7000;
        for (int p = 0; p < NEXP; p++) cfg(1'b1, p, lnv[p]);
        c0 = cyc;
        mode_g = 0; rmode = 0; item_idx = 0; item_cnt = 256;
        while (item_idx < item_cnt) step();
        check(cyc - c0 == 256, "R5 throughput", cyc - c0, 256);
        while (q.size() != 0 || out_valid) step();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R5 watchdog expired actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule